// File: doc/BRIEF.md
# Sampled Position Controller with Integral Action

This block closes a position loop in integer arithmetic. Each time the sample strobe is seen while the block is idle, it captures two measured states and a reference, all 10-bit two's-complement integers. It forms a weighted sum of the first state, the second state and an internal integrator. The weights are Q4.12 gains, and the products are summed at 32 bits. The sum is then scaled down by twelve fractional bits and clamped to the 10-bit output range.

Only after the command is produced does the integrator absorb the tracking error (reference minus second state). It does so with 16-bit saturating arithmetic. One shared multiplier serves all three products over three consecutive cycles. A done pulse marks the cycle in which the new command and the new integrator value first appear. The gains are elaboration-time parameters, so other coefficient sets can be built without changing the logic.

Top module: `sfb_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the command output and integrator output are 0, and done and busy are low.
- R2: A strobe is accepted only while busy is low. Input values are captured in that cycle. Later changes of the inputs, and strobes that arrive while busy is high, change neither the result of the sample in flight nor the integrator.
- R3: Count the rising edge that accepts a strobe as edge 1. The done output is high for exactly one cycle after edge 5. The command and integrator outputs change only at that edge and hold at all other times.
- R4: The command is u = clamp((K1*y1 + K2*y2 + K3*I) taken modulo 2^32 as signed, shifted right arithmetically by 12). I is the integrator value before this sample's update. The default gains are K1 = -20764, K2 = -23288 and K3 = 2480.
- R5: A shifted sum of 512 or more gives a command of 511, and a shifted sum below -512 gives -512.
- R6: At the done edge, the integrator becomes I + r - y2, using the captured reference r and second state y2.
- R7: The integrator update saturates at 32767 and -32768 instead of wrapping.
- R8: The scaling rounds toward minus infinity. With the default gains, y1 = 1 and zero for the other terms gives -6, and y1 = -1 gives 5.
- R9: Busy is high from the accepting edge until the done edge, and is never high at the same time as done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Sample strobe |
| y1_i | input | 10 | First measured state, signed |
| y2_i | input | 10 | Second measured state, signed |
| ref_i | input | 10 | Reference, signed |
| u_o | output | 10 | Saturated command, signed |
| integ_o | output | 16 | Integrator value, signed |
| done_o | output | 1 | One-cycle pulse when u_o and integ_o are new |
| busy_o | output | 1 | A sample is being computed |

## Verification
A wrong accumulator or a wrong operand select gives a wrong command on the very done pulse of that sample. A wrong integrator update only changes the command on the next sample, but because integ_o is a port, it is also visible at once on the same pulse. A sequencing fault moves or repeats the done pulse, and the bench catches this on the first sample, because it checks the cycle position of done on every transaction. Sweeping every value of each state exposes clamp and rounding faults at the exact input where they begin.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_P1,
        ST_P2,
        ST_P3,
        ST_OUT
    } sfb_state_e;

    typedef enum logic [1:0] {
        SEL_Y1,
        SEL_Y2,
        SEL_INT
    } sfb_sel_e;

    typedef struct packed {
        logic     en;
        logic     clr;
        sfb_sel_e sel;
    } mac_ctrl_t;

endpackage

// File: rtl/sfb_seq.sv
module sfb_seq
    import sfb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output mac_ctrl_t ctrl,
    output logic      busy,
    output logic      fin
);

    sfb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        ctrl.en  = 1'b0;
        ctrl.clr = 1'b0;
        ctrl.sel = SEL_Y1;
        fin      = 1'b0;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_P1;
            ST_P1: begin
                ctrl.en  = 1'b1;
                ctrl.clr = 1'b1;
                ctrl.sel = SEL_Y1;
                state_d  = ST_P2;
            end
            ST_P2: begin
                ctrl.en  = 1'b1;
                ctrl.sel = SEL_Y2;
                state_d  = ST_P3;
            end
            ST_P3: begin
                ctrl.en  = 1'b1;
                ctrl.sel = SEL_INT;
                state_d  = ST_OUT;
            end
            ST_OUT: begin
                fin     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/sfb_mac.sv
module sfb_mac
    import sfb_pkg::*;
#(
    parameter int SIG_W  = 10,
    parameter int INT_W  = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32,
    parameter logic signed [COEF_W-1:0] K1 = -16'sd20764,
    parameter logic signed [COEF_W-1:0] K2 = -16'sd23288,
    parameter logic signed [COEF_W-1:0] K3 = 16'sd2480
) (
    input  logic                     clk,
    input  logic                     rst,
    input  mac_ctrl_t                ctrl,
    input  logic signed [SIG_W-1:0]  y1,
    input  logic signed [SIG_W-1:0]  y2,
    input  logic signed [INT_W-1:0]  integ,
    output logic signed [ACC_W-1:0]  acc_o
);

    localparam int PROD_W = COEF_W + INT_W;

    logic signed [INT_W-1:0]  op;
    logic signed [COEF_W-1:0] cf;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  base;

    always_comb begin
        case (ctrl.sel)
            SEL_Y1:  begin op = INT_W'(y1); cf = K1; end
            SEL_Y2:  begin op = INT_W'(y2); cf = K2; end
            SEL_INT: begin op = integ;      cf = K3; end
            default: begin op = '0;         cf = '0; end
        endcase
    end

    assign prod = PROD_W'(op) * PROD_W'(cf);
    assign base = ctrl.clr ? '0 : acc_o;

    always_ff @(posedge clk) begin
        if (rst)          acc_o <= '0;
        else if (ctrl.en) acc_o <= base + ACC_W'(prod);
    end

endmodule

// File: rtl/sfb_post.sv
module sfb_post #(
    parameter int SIG_W = 10,
    parameter int INT_W = 16,
    parameter int ACC_W = 32,
    parameter int FRAC  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fin,
    input  logic signed [ACC_W-1:0]  acc,
    input  logic signed [SIG_W-1:0]  ref_q,
    input  logic signed [SIG_W-1:0]  y2_q,
    output logic signed [SIG_W-1:0]  u_o,
    output logic signed [INT_W-1:0]  integ_o,
    output logic                     done_o
);

    localparam int SUM_W = INT_W + 2;
    localparam logic signed [ACC_W-1:0] U_HI = ACC_W'((64'sd1 <<< (SIG_W-1)) - 1);
    localparam logic signed [ACC_W-1:0] U_LO = -U_HI - 1;
    localparam logic signed [SUM_W-1:0] I_HI = SUM_W'((64'sd1 <<< (INT_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] I_LO = -I_HI - 1;

    logic signed [ACC_W-1:0] shifted;
    logic signed [SIG_W-1:0] u_d;
    logic signed [SUM_W-1:0] isum;
    logic signed [INT_W-1:0] i_d;

    assign shifted = acc >>> FRAC;

    always_comb begin
        if (shifted > U_HI)      u_d = U_HI[SIG_W-1:0];
        else if (shifted < U_LO) u_d = U_LO[SIG_W-1:0];
        else                     u_d = shifted[SIG_W-1:0];
    end

    assign isum = SUM_W'(integ_o) + SUM_W'(ref_q) - SUM_W'(y2_q);

    always_comb begin
        if (isum > I_HI)      i_d = I_HI[INT_W-1:0];
        else if (isum < I_LO) i_d = I_LO[INT_W-1:0];
        else                  i_d = isum[INT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            u_o     <= '0;
            integ_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= fin;
            if (fin) begin
                u_o     <= u_d;
                integ_o <= i_d;
            end
        end
    end

endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl
    import sfb_pkg::*;
#(
    parameter int SIG_W  = 10,
    parameter int INT_W  = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32,
    parameter int FRAC   = 12,
    parameter logic signed [COEF_W-1:0] K1 = -16'sd20764,
    parameter logic signed [COEF_W-1:0] K2 = -16'sd23288,
    parameter logic signed [COEF_W-1:0] K3 = 16'sd2480
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_i,
    input  logic signed [SIG_W-1:0] y1_i,
    input  logic signed [SIG_W-1:0] y2_i,
    input  logic signed [SIG_W-1:0] ref_i,
    output logic signed [SIG_W-1:0] u_o,
    output logic signed [INT_W-1:0] integ_o,
    output logic                    done_o,
    output logic                    busy_o
);

    mac_ctrl_t               ctrl;
    logic                    start;
    logic                    fin;
    logic signed [SIG_W-1:0] y1_q, y2_q, ref_q;
    logic signed [ACC_W-1:0] acc;

    assign start = sample_i && !busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            y1_q  <= '0;
            y2_q  <= '0;
            ref_q <= '0;
        end else if (start) begin
            y1_q  <= y1_i;
            y2_q  <= y2_i;
            ref_q <= ref_i;
        end
    end

    sfb_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctrl  (ctrl),
        .busy  (busy_o),
        .fin   (fin)
    );

    sfb_mac #(
        .SIG_W (SIG_W), .INT_W (INT_W), .COEF_W (COEF_W), .ACC_W (ACC_W),
        .K1 (K1), .K2 (K2), .K3 (K3)
    ) u_mac (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .y1    (y1_q),
        .y2    (y2_q),
        .integ (integ_o),
        .acc_o (acc)
    );

    sfb_post #(
        .SIG_W (SIG_W), .INT_W (INT_W), .ACC_W (ACC_W), .FRAC (FRAC)
    ) u_post (
        .clk     (clk),
        .rst     (rst),
        .fin     (fin),
        .acc     (acc),
        .ref_q   (ref_q),
        .y2_q    (y2_q),
        .u_o     (u_o),
        .integ_o (integ_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/sfb_chk.sv
module sfb_chk #(
    parameter int SIG_W = 10,
    parameter int INT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sample_i,
    input logic signed [SIG_W-1:0] u_o,
    input logic signed [INT_W-1:0] integ_o,
    input logic                    done_o,
    input logic                    busy_o
);

    localparam int DW = INT_W + 2;
    localparam logic signed [DW-1:0] STEP_MAX = DW'((64'sd1 <<< SIG_W) - 1);

    logic signed [INT_W-1:0] integ_prev;
    logic signed [DW-1:0]    step;

    always_ff @(posedge clk) integ_prev <= integ_o;

    assign step = DW'(integ_o) - DW'(integ_prev);

    // R3: the done pulse lasts a single cycle
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2: work starts only in answer to a strobe
    assert_start_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(sample_i));

    // R9: done follows a busy period and never overlaps it
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

    // R3: the command changes only with done
    assert_u_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(u_o) |-> done_o);

    // R3: the integrator changes only with done
    assert_integ_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(integ_o) |-> done_o);

    // R6: one update moves the integrator by at most the largest error
    assert_integ_step_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (step <= STEP_MAX && step >= -STEP_MAX));

endmodule

bind sfb_ctrl sfb_chk #(.SIG_W(SIG_W), .INT_W(INT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sample_i (sample_i),
    .u_o      (u_o),
    .integ_o  (integ_o),
    .done_o   (done_o),
    .busy_o   (busy_o)
);

// File: tb/tb_sfb_ctrl.sv
module tb_sfb_ctrl;

    localparam int G1 = -20764;
    localparam int G2 = -23288;
    localparam int G3 = 2480;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_i = 1'b0;
    logic signed [9:0]  y1_i = '0, y2_i = '0, ref_i = '0;
    logic signed [9:0]  u_o;
    logic signed [15:0] integ_o;
    logic done_o, busy_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  model_i = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    sfb_ctrl dut (
        .clk (clk), .rst (rst), .sample_i (sample_i),
        .y1_i (y1_i), .y2_i (y2_i), .ref_i (ref_i),
        .u_o (u_o), .integ_o (integ_o), .done_o (done_o), .busy_o (busy_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp(input longint v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return int'(v);
    endfunction

    function automatic int model_u(input int a, input int b, input int i);
        longint s;
        int     w;
        s = longint'(G1) * a + longint'(G2) * b + longint'(G3) * i;
        w = int'(s);
        return clamp(w >>> 12, -512, 511);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset u", u_o, 0);
        check("R1 reset integ", integ_o, 0);
        check("R1 reset done/busy", {done_o, busy_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset idle", {done_o, busy_o, integ_o}, 0);
        model_i = 0;
    endtask

    // one transaction, checks latency, command and integrator
    task automatic run(input int a, input int b, input int r, input string req);
        bit lat_ok;
        int eu;
        @(negedge clk);
        sample_i = 1'b1;
        y1_i = 10'(a); y2_i = 10'(b); ref_i = 10'(r);
        @(negedge clk);
        sample_i = 1'b0;
        lat_ok = 1'b1;
        repeat (4) begin
            if (done_o || !busy_o) lat_ok = 1'b0;
            @(negedge clk);
        end
        if (!done_o || busy_o) lat_ok = 1'b0;
        check("R3/R9 done timing", lat_ok, 1);
        eu = model_u(a, b, model_i);
        model_i = clamp(longint'(model_i) + r - b, -32768, 32767);
        check(req, u_o, eu);
        check("R6/R7 integrator", integ_o, model_i);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R8: rounding toward minus infinity
        run(1, 0, 0, "R8 y1=1");
        check("R8 explicit -6", u_o, -6);
        run(-1, 0, 0, "R8 y1=-1");
        check("R8 explicit 5", u_o, 5);

        // R4/R5: sweep first state, integrator held at zero
        for (int v = -512; v <= 511; v++) run(v, 0, 0, "R4/R5 y1 sweep");
        check("R5 clamp high", model_u(-512, 0, 0), 511);

        // R4/R5: sweep second state, reference equal so integrator stays 0
        for (int v = -512; v <= 511; v++) run(0, v, v, "R4/R5 y2 sweep");
        check("R6 integrator unchanged", integ_o, 0);

        // R7: drive integrator to positive limit
        for (int k = 0; k < 40; k++) run(0, -512, 511, "R4/R5 integ up");
        check("R7 positive saturation", integ_o, 32767);
        check("R5 output at high limit", u_o, 511);
        // R7: drive to negative limit
        for (int k = 0; k < 75; k++) run(0, 511, -512, "R4/R5 integ down");
        check("R7 negative saturation", integ_o, -32768);
        check("R5 output at low limit", u_o, -512);

        // R2: strobe and input changes while busy are ignored
        do_reset();
        begin
            bit quiet;
            int eu;
            @(negedge clk);
            sample_i = 1'b1; y1_i = 10'sd100; y2_i = -10'sd50; ref_i = 10'sd30;
            @(negedge clk);
            sample_i = 1'b0;
            @(negedge clk);
            sample_i = 1'b1; y1_i = -10'sd400; y2_i = 10'sd300; ref_i = -10'sd200;
            @(negedge clk);
            sample_i = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check("R2/R3 done for first only", done_o, 1);
            eu = model_u(100, -50, 0);
            model_i = 80;
            check("R2 result from captured inputs", u_o, eu);
            check("R2 integrator updated once", integ_o, 80);
            quiet = 1'b1;
            repeat (8) begin
                @(negedge clk);
                if (done_o || busy_o) quiet = 1'b0;
            end
            check("R2 ignored strobe started nothing", quiet, 1);
            check("R2 integrator held", integ_o, 80);
        end

        // R4/R6: random sequences against the model
        for (int k = 0; k < 1500; k++)
            run($urandom_range(1023) - 512, $urandom_range(1023) - 512,
                $urandom_range(1023) - 512, "R4 random");

        // R1: reset mid-run clears the integrator
        do_reset();
        run(7, 3, 9, "R4 after reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule